// File: doc/BRIEF.md
# Strapped-Address Indirect Management Bridge

This block is the device-side front end of a management register path. An external access port gives a 5-bit device address, a 5-bit register address, a read/write strobe and 16-bit data. An internal parallel bus reaches up to 32 internal devices, each with 32 registers. A 4-bit strap input sets the block's own address. The strap value forms bits 4:1 of that address and bit 0 is always zero.

When the strap is zero, the block answers at every external device address. Each access goes straight to the internal device with the same number, in the same cycle. When the strap is non-zero, the block answers only at its own even address. There it offers a command register and a data register. Software first loads data, then writes a command with the busy bit set. It then polls until busy reads 0. The internal access is carried out `ACC_CYCLES` cycles after the command, on the final cycle of the busy phase. Read results are placed in the data register.

Top module: `smib_top`

## Requirements
- R1: The own address is {strap, 0}. With a non-zero strap, `ext_sel` rises for a strobe only when `ext_dev` equals that address, so an odd device address is never selected.
- R2: With a zero strap, every strobe is selected and forwarded in the same cycle. `int_stb`, `int_dev`, `int_rix`, `int_we` and `int_wdata` follow the external port. `int_c22` is 1 and `int_op` is 01 for a write and 10 for a read. A read returns `int_rdata` on `ext_rdata`.
- R3: In indirect mode, register 0 is command and register 1 is data. Any other register reads 0 and ignores writes. The command reads back as bit 15 busy, bit 12 mode (1 = clause-22 style, 0 = clause-45 style), bits 11:10 opcode, bits 9:5 target device and bits 4:0 target register, with bits 14:13 reading 0.
- R4: A command written with bit 15 set makes busy read 1 for exactly `ACC_CYCLES` cycles, after which it clears by itself. Exactly one internal strobe is issued, in the last busy cycle, carrying the command's device, register, mode and opcode.
- R5: Write opcodes drive `int_we`=1 and put the data register's value on `int_wdata`. The write opcodes are 01 in clause-22 mode and 00 or 01 in clause-45 mode.
- R6: Read opcodes drive `int_we`=0, and `int_rdata` is stored in the data register when the access completes. The read opcodes are 10 in clause-22 mode and 10 or 11 in clause-45 mode.
- R7: Clause-22 opcodes 00 and 11 run the busy phase but issue no internal strobe and leave the data register unchanged.
- R8: A command written with bit 15 clear updates the command fields but starts nothing: busy stays 0 and no strobe is issued.
- R9: Writes to the command or data register while busy is 1 are ignored, and the running access keeps its fields and write value.
- R10: In indirect mode, unselected strobes cause no internal strobe and `ext_rdata` stays 0.
- R11: After reset, command and data read 0, busy is 0 and no internal strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | 4 | Own-address bits 4:1; zero selects pass-through |
| ext_stb | input | 1 | External access strobe, one cycle per access |
| ext_we | input | 1 | 1 = write, 0 = read |
| ext_dev | input | 5 | External device address |
| ext_rix | input | 5 | External register address |
| ext_wdata | input | 16 | External write data |
| ext_sel | output | 1 | Block answers the current strobe |
| ext_rdata | output | 16 | Read data, valid during a selected read strobe |
| int_stb | output | 1 | Internal access strobe |
| int_we | output | 1 | Internal write enable |
| int_c22 | output | 1 | Internal mode: 1 clause-22 style, 0 clause-45 style |
| int_op | output | 2 | Internal opcode |
| int_dev | output | 5 | Internal device number |
| int_rix | output | 5 | Internal register number |
| int_wdata | output | 16 | Internal write data |
| int_rdata | input | 16 | Internal read data for the addressed register |

## Verification
A busy counter loaded with the wrong count shows up on the very next command poll, as too few or too many busy reads. A wrong opcode decode becomes visible on the internal bus in the last busy cycle: the bus either carries a write enable of the wrong polarity or the expected strobe never appears. A stored field or data value corrupted during the busy phase surfaces in two ways. The write value or target at the completion strobe is wrong, or the readback of the data register differs from the internal device's response one cycle after busy clears. Address-decode faults appear in the same cycle as the strobe, on `ext_sel` and on the internal bus.

// File: rtl/smib_pkg.sv
package smib_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int STRAP_W  = ADDR_W - 1;
  localparam int OP_W     = 2;
  localparam int BUSY_BIT = 15;
  localparam int MODE_BIT = 12;
  localparam int OP_LSB   = 10;
  localparam int DEV_LSB  = 5;
  localparam int RIX_LSB  = 0;
  localparam logic [ADDR_W-1:0] CMD_OFS  = 5'd0;
  localparam logic [ADDR_W-1:0] DATA_OFS = 5'd1;

  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_WR = 2'd1, ACC_RD = 2'd2} acc_kind_e;

  // Opcode classification for both command modes.
  function automatic acc_kind_e classify(input logic c22, input logic [OP_W-1:0] op);
    acc_kind_e k;
    if (c22) begin
      case (op)
        2'b01:   k = ACC_WR;
        2'b10:   k = ACC_RD;
        default: k = ACC_NONE;
      endcase
    end else begin
      k = op[1] ? ACC_RD : ACC_WR;
    end
    return k;
  endfunction

  function automatic logic [DATA_W-1:0] pack_cmd(input logic busy, input logic c22,
      input logic [OP_W-1:0] op, input logic [ADDR_W-1:0] dev, input logic [ADDR_W-1:0] rix);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BUSY_BIT] = busy;
    w[MODE_BIT] = c22;
    w[OP_LSB +: OP_W] = op;
    w[DEV_LSB +: ADDR_W] = dev;
    w[RIX_LSB +: ADDR_W] = rix;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] own_addr(input logic [STRAP_W-1:0] s);
    return {s, 1'b0};
  endfunction
endpackage

// File: rtl/smib_decode.sv
module smib_decode
  import smib_pkg::*;
(
  input  logic [STRAP_W-1:0] strap,
  input  logic               ext_stb,
  input  logic               ext_we,
  input  logic [ADDR_W-1:0]  ext_dev,
  input  logic [ADDR_W-1:0]  ext_rix,
  output logic               direct,
  output logic               sel,
  output logic               wr_cmd,
  output logic               wr_data,
  output logic               rd_cmd,
  output logic               rd_data
);
  logic hit_cmd, hit_data;

  always_comb begin
    direct   = (strap == '0);
    sel      = ext_stb && (direct || (ext_dev == own_addr(strap)));
    hit_cmd  = sel && !direct && (ext_rix == CMD_OFS);
    hit_data = sel && !direct && (ext_rix == DATA_OFS);
    wr_cmd   = hit_cmd && ext_we;
    wr_data  = hit_data && ext_we;
    rd_cmd   = hit_cmd && !ext_we;
    rd_data  = hit_data && !ext_we;
  end
endmodule

// File: rtl/smib_engine.sv
module smib_engine
  import smib_pkg::*;
#(
  parameter int ACC_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wr_cmd,
  input  logic               wr_data,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic [DATA_W-1:0]  cmd_word,
  output logic [DATA_W-1:0]  data_word,
  output logic               busy,
  output logic               done,
  output logic               start,
  output logic               is_rd,
  output logic               bus_stb,
  output logic               bus_we,
  output logic               bus_c22,
  output logic [OP_W-1:0]    bus_op,
  output logic [ADDR_W-1:0]  bus_dev,
  output logic [ADDR_W-1:0]  bus_rix,
  output logic [DATA_W-1:0]  bus_wdata
);
  localparam int CW = $clog2(ACC_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(ACC_CYCLES - 1);

  logic              busy_q, c22_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] dev_q, rix_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] data_q;
  acc_kind_e         kind;
  logic              take_cmd, take_data;

  always_comb begin
    kind      = classify(c22_q, op_q);
    take_cmd  = en && wr_cmd && !busy_q;
    take_data = en && wr_data && !busy_q;
    done      = busy_q && (cnt_q == '0);
    start     = take_cmd && wdata[BUSY_BIT];
    is_rd     = (kind == ACC_RD);
    busy      = busy_q;
    cmd_word  = pack_cmd(busy_q, c22_q, op_q, dev_q, rix_q);
    data_word = data_q;
    bus_stb   = done && (kind != ACC_NONE);
    bus_we    = (kind == ACC_WR);
    bus_c22   = c22_q;
    bus_op    = op_q;
    bus_dev   = dev_q;
    bus_rix   = rix_q;
    bus_wdata = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      c22_q  <= 1'b0;
      op_q   <= '0;
      dev_q  <= '0;
      rix_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      if (take_cmd) begin
        busy_q <= wdata[BUSY_BIT];
        c22_q  <= wdata[MODE_BIT];
        op_q   <= wdata[OP_LSB +: OP_W];
        dev_q  <= wdata[DEV_LSB +: ADDR_W];
        rix_q  <= wdata[RIX_LSB +: ADDR_W];
        cnt_q  <= LOAD;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (take_data) begin
        data_q <= wdata;
      end else if (done && is_rd) begin
        data_q <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/smib_top.sv
module smib_top
  import smib_pkg::*;
#(
  parameter int ACC_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   strap,
  input  logic         ext_stb,
  input  logic         ext_we,
  input  logic [4:0]   ext_dev,
  input  logic [4:0]   ext_rix,
  input  logic [15:0]  ext_wdata,
  output logic         ext_sel,
  output logic [15:0]  ext_rdata,
  output logic         int_stb,
  output logic         int_we,
  output logic         int_c22,
  output logic [1:0]   int_op,
  output logic [4:0]   int_dev,
  output logic [4:0]   int_rix,
  output logic [15:0]  int_wdata,
  input  logic [15:0]  int_rdata
);
  logic direct_mode, wr_cmd, wr_data, rd_cmd, rd_data;
  logic [DATA_W-1:0] eng_cmd, eng_data, e_wdata;
  logic eng_busy, eng_done, eng_start, eng_rd;
  logic e_stb, e_we, e_c22;
  logic [OP_W-1:0] e_op;
  logic [ADDR_W-1:0] e_dev, e_rix;

  smib_decode u_dec (
    .strap(strap), .ext_stb(ext_stb), .ext_we(ext_we), .ext_dev(ext_dev), .ext_rix(ext_rix),
    .direct(direct_mode), .sel(ext_sel), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .rd_cmd(rd_cmd), .rd_data(rd_data)
  );

  smib_engine #(.ACC_CYCLES(ACC_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(!direct_mode), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .wdata(ext_wdata), .bus_rdata(int_rdata), .cmd_word(eng_cmd), .data_word(eng_data),
    .busy(eng_busy), .done(eng_done), .start(eng_start), .is_rd(eng_rd),
    .bus_stb(e_stb), .bus_we(e_we), .bus_c22(e_c22), .bus_op(e_op),
    .bus_dev(e_dev), .bus_rix(e_rix), .bus_wdata(e_wdata)
  );

  always_comb begin
    if (direct_mode) begin
      int_stb   = ext_stb;
      int_we    = ext_we;
      int_c22   = 1'b1;
      int_op    = ext_we ? 2'b01 : 2'b10;
      int_dev   = ext_dev;
      int_rix   = ext_rix;
      int_wdata = ext_wdata;
      ext_rdata = (ext_stb && !ext_we) ? int_rdata : '0;
    end else begin
      int_stb   = e_stb;
      int_we    = e_we;
      int_c22   = e_c22;
      int_op    = e_op;
      int_dev   = e_dev;
      int_rix   = e_rix;
      int_wdata = e_wdata;
      ext_rdata = rd_cmd ? eng_cmd : (rd_data ? eng_data : '0);
    end
  end
endmodule

// File: rtl/smib_checks.sv
module smib_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  strap,
  input logic        ext_stb,
  input logic        ext_sel,
  input logic [4:0]  ext_dev,
  input logic [4:0]  ext_rix,
  input logic        int_stb,
  input logic        int_c22,
  input logic [1:0]  int_op,
  input logic [4:0]  int_dev,
  input logic [4:0]  int_rix,
  input logic [15:0] int_rdata,
  input logic        eng_busy,
  input logic        eng_done,
  input logic        eng_start,
  input logic        eng_rd,
  input logic [15:0] eng_data
);
  assert_sel_own_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strap != 4'd0 && ext_sel) |-> (ext_dev == {strap, 1'b0}));

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strap == 4'd0 && ext_stb) |-> (int_stb && int_dev == ext_dev && int_rix == ext_rix));

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> eng_busy);

  assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !eng_busy);

  assert_read_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_rd) |=> (eng_data == $past(int_rdata)));

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap != 4'd0 && int_stb) |-> (!int_c22 || int_op == 2'b01 || int_op == 2'b10));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !eng_done) |=> $stable(eng_data));

  assert_no_stray_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strap != 4'd0 && int_stb) |-> eng_busy);
endmodule

bind smib_top smib_checks u_chk (
  .clk(clk), .rst_n(rst_n), .strap(strap), .ext_stb(ext_stb), .ext_sel(ext_sel),
  .ext_dev(ext_dev), .ext_rix(ext_rix), .int_stb(int_stb), .int_c22(int_c22),
  .int_op(int_op), .int_dev(int_dev), .int_rix(int_rix), .int_rdata(int_rdata),
  .eng_busy(eng_busy), .eng_done(eng_done), .eng_start(eng_start), .eng_rd(eng_rd),
  .eng_data(eng_data)
);

// File: tb/smib_top_bench.sv
module smib_top_bench;
  localparam int ACC = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] strap = 4'd0;
  logic ext_stb = 1'b0, ext_we = 1'b0;
  logic [4:0] ext_dev = '0, ext_rix = '0;
  logic [15:0] ext_wdata = '0;
  logic ext_sel, int_stb, int_we, int_c22;
  logic [15:0] ext_rdata, int_wdata, int_rdata;
  logic [1:0] int_op;
  logic [4:0] int_dev, int_rix;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  smib_top #(.ACC_CYCLES(ACC)) u_smib_top (.*);

  function automatic logic [15:0] resp(input logic [4:0] d, input logic [4:0] r);
    return {1'b1, d, r, d ^ r};
  endfunction
  assign int_rdata = resp(int_dev, int_rix);

  // internal strobe log (indirect mode strobes depend on registers only)
  int stb_cnt = 0;
  logic lg_we, lg_c22;
  logic [1:0] lg_op;
  logic [4:0] lg_dev, lg_rix;
  logic [15:0] lg_wdata;
  always @(negedge clk) if (rst_n && int_stb) begin
    stb_cnt++; lg_we = int_we; lg_c22 = int_c22; lg_op = int_op;
    lg_dev = int_dev; lg_rix = int_rix; lg_wdata = int_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
    ext_stb = 1'b1; ext_we = 1'b1; ext_dev = d; ext_rix = r; ext_wdata = v;
    @(negedge clk);
    ext_stb = 1'b0; ext_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] d, input logic [4:0] r, output logic [15:0] v, output logic s);
    ext_stb = 1'b1; ext_we = 1'b0; ext_dev = d; ext_rix = r;
    #1 v = ext_rdata; s = ext_sel;
    @(negedge clk);
    ext_stb = 1'b0;
  endtask

  function automatic int kind(input logic c22, input logic [1:0] op);
    if (!c22) return (op >= 2'b10) ? 2 : 1;
    if (op == 2'b01) return 1;
    if (op == 2'b10) return 2;
    return 0;
  endfunction

  // one indirect access; returns busy read count
  task automatic ind_op(input logic [4:0] own, input logic c22, input logic [1:0] op,
                        input logic [4:0] d, input logic [4:0] r, input logic [15:0] v,
                        input bit dirty);
    logic [15:0] x; logic s; int n; int c0; int k;
    wr(own, 5'd1, v);
    c0 = stb_cnt;
    wr(own, 5'd0, {1'b1, 2'b11, c22, op, d, r});
    if (dirty) begin
      wr(own, 5'd1, ~v);
      wr(own, 5'd0, 16'h8000 | {6'd0, 5'd0, 5'd7});
    end
    n = dirty ? 2 : 0;
    for (int i = 0; i < 40; i++) begin
      rd(own, 5'd0, x, s);
      if (!x[15]) break;
      n++;
    end
    k = kind(c22, op);
    chk("R4 busy cycles", n, ACC);
    chk("R3 cmd readback", x, {4'b0001 & {3'b000, c22}, op, d, r} | 16'h0000);
    chk(k == 0 ? "R7 strobe count" : "R4 strobe count", stb_cnt - c0, k == 0 ? 0 : 1);
    if (k != 0) chk("R4 strobe fields", {lg_c22, lg_op, lg_dev, lg_rix}, {c22, op, d, r});
    rd(own, 5'd1, x, s);
    if (k == 1) begin
      chk(dirty ? "R9 write kept" : "R5 write value", {lg_we, lg_wdata}, {1'b1, v});
      chk("R5 data unchanged", x, v);
    end else if (k == 2) begin
      chk("R6 read enable", lg_we, 1'b0);
      chk(dirty ? "R9 read result" : "R6 read result", x, resp(d, r));
    end else begin
      chk("R7 data unchanged", x, v);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] x; logic s; int c0;
    void'($urandom(32'h5EED));
    // ---------------- direct mode ----------------
    do_reset(4'd0);
    #1 chk("R11 no strobe after reset", int_stb, 1'b0);
    for (int i = 0; i < 40; i++) begin
      logic [4:0] d, r; logic w; logic [15:0] v;
      d = 5'($urandom); r = 5'($urandom); w = 1'($urandom); v = 16'($urandom);
      ext_stb = 1'b1; ext_we = w; ext_dev = d; ext_rix = r; ext_wdata = v;
      #1;
      chk("R2 pass fields", {ext_sel, int_stb, int_we, int_c22, int_op, int_dev, int_rix},
          {1'b1, 1'b1, w, 1'b1, w ? 2'b01 : 2'b10, d, r});
      if (w) chk("R2 pass wdata", int_wdata, v);
      else   chk("R2 pass rdata", ext_rdata, resp(d, r));
      @(negedge clk); ext_stb = 1'b0;
    end
    // ---------------- indirect mode, own 0x0A ----------------
    do_reset(4'h5);
    rd(5'h0A, 5'd0, x, s);
    chk("R11 cmd reset", {s, x}, {1'b1, 16'h0000});
    rd(5'h0A, 5'd1, x, s);
    chk("R11 data reset", x, 16'h0000);
    rd(5'h0B, 5'd0, x, s);
    chk("R1 odd address unselected", {s, x}, 17'h0);
    rd(5'h0C, 5'd1, x, s);
    chk("R1 other address unselected", {s, x}, 17'h0);
    c0 = stb_cnt;
    wr(5'h0B, 5'd0, 16'h9FFF);
    wr(5'h04, 5'd1, 16'h1234);
    rd(5'h0A, 5'd0, x, s);
    chk("R10 foreign write ignored", {stb_cnt - c0, x}, {32'd0, 16'h0000});
    wr(5'h0A, 5'd5, 16'hBEEF);
    rd(5'h0A, 5'd5, x, s);
    chk("R3 spare register reads zero", {s, x}, {1'b1, 16'h0000});
    rd(5'h0A, 5'd1, x, s);
    chk("R3 spare write no effect", x, 16'h0000);
    c0 = stb_cnt;
    wr(5'h0A, 5'd0, 16'h7FFF);
    rd(5'h0A, 5'd0, x, s);
    chk("R8 no-start cmd fields", x, 16'h1FFF);
    chk("R8 no strobe", stb_cnt - c0, 0);
    // directed opcodes
    ind_op(5'h0A, 1'b1, 2'b01, 5'd3, 5'd9, 16'hA5A5, 1'b0);
    ind_op(5'h0A, 1'b1, 2'b10, 5'd31, 5'd0, 16'h0F0F, 1'b0);
    ind_op(5'h0A, 1'b1, 2'b00, 5'd1, 5'd2, 16'h1111, 1'b0);
    ind_op(5'h0A, 1'b1, 2'b11, 5'd4, 5'd8, 16'h2222, 1'b0);
    ind_op(5'h0A, 1'b0, 2'b00, 5'd6, 5'd1, 16'h3333, 1'b0);
    ind_op(5'h0A, 1'b0, 2'b11, 5'd7, 5'd30, 16'h4444, 1'b0);
    // writes during busy are ignored
    ind_op(5'h0A, 1'b1, 2'b01, 5'd10, 5'd11, 16'hC0DE, 1'b1);
    ind_op(5'h0A, 1'b0, 2'b10, 5'd12, 5'd13, 16'hFACE, 1'b1);
    for (int i = 0; i < 25; i++)
      ind_op(5'h0A, 1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 1'b0);
    // ---------------- indirect mode, own 0x1E ----------------
    do_reset(4'hF);
    rd(5'h1F, 5'd0, x, s);
    chk("R1 odd top address unselected", s, 1'b0);
    for (int i = 0; i < 10; i++)
      ind_op(5'h1E, 1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule